// File: doc/BRIEF.md
# Delay Calibration Parameter Calculator

This block turns the calibration counts captured at boot into two per-element delay step values, one for the coarse delay line and one for the fine delay line. A start strobe samples three 32-bit words. The first is the reference clock period, taken from its low 16 bits. The other two are calibration words, each packing a delay count and a reference count. The block then works the two ratios out in turn on one shared serial divider.

Each step value is `(10 * period * ref_count) / (2 * delay_count * M)`. The operands are 64 bits wide and the quotient is truncated to 32 bits. M is 88 for the coarse line and 264 for the fine line. The coarse value is worked out and validated first. A zero delay count stops the sequence before its division, and a zero quotient is rejected. Each failure reports its own error code and leaves the published step values as they were. A one-cycle done pulse closes every sequence, whether it passed or failed.

Top module: `calib_param_calc`

## Requirements
- R1: After reset, both step outputs are 0, done_o is low and err_o is 0.
- R2: Only bits 15:0 of period_reg_i are used as the period; bits 31:16 have no effect on any result.
- R3: In coarse_reg_i and fine_reg_i, bits 31:16 hold the delay count and bits 15:0 hold the reference count.
- R4: On success, coarse_step_o equals floor(10*period*coarse_ref / (2*coarse_delay*88)) truncated to 32 bits, computed with 64-bit operands.
- R5: On success, fine_step_o equals floor(10*period*fine_ref / (2*fine_delay*264)) truncated to 32 bits.
- R6: A zero coarse delay count ends the sequence with err_o = 1, and done_o is high in the cycle after the edge that follows the start edge.
- R7: A zero coarse quotient ends the sequence with err_o = 2, and done_o is high after the 66th edge past the start edge.
- R8: A zero fine delay count ends the sequence with err_o = 3, after the 67th edge. A coarse failure takes priority, and the fine step is then skipped.
- R9: A zero fine quotient ends the sequence with err_o = 4, after the 132nd edge. A successful sequence also completes after the 132nd edge, with err_o = 0.
- R10: On any error both step outputs keep their previous values. err_o holds the last sequence's code until the next done.
- R11: done_o is high for exactly one cycle per sequence.
- R12: Input words are sampled at the start edge only. Later changes to the inputs, and start pulses that arrive while a sequence is running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| period_reg_i | input | 32 | Reference period word (low 16 bits used) |
| coarse_reg_i | input | 32 | Coarse calibration word: delay count in bits 31:16, reference count in bits 15:0 |
| fine_reg_i | input | 32 | Fine calibration word: delay count in bits 31:16, reference count in bits 15:0 |
| coarse_step_o | output | 32 | Coarse per-element step value |
| fine_step_o | output | 32 | Fine per-element step value |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 3 | 0 ok, 1 zero coarse count, 2 zero coarse quotient, 3 zero fine count, 4 zero fine quotient |

## Verification
The time to done depends on where the sequence stops. Counted in clock edges after the start edge, it is 1 for a zero coarse count, 66 for a zero coarse quotient, 67 for a zero fine count, and 132 for a zero fine quotient or for success. For every sequence the bench derives the expected stopping point, code and step values from its own model. It then counts edges from the start edge, sampling at each falling edge, and requires done to first appear on exactly the predicted edge. One falling edge later, it checks that done has dropped and that the error code is unchanged. Some sequences also receive extra start pulses and altered input words while they run.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK_C, ST_WAIT_C, ST_CHK_F, ST_WAIT_F
  } calib_state_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_C_CNT = 3'd1,
    ERR_C_RES = 3'd2,
    ERR_F_CNT = 3'd3,
    ERR_F_RES = 3'd4
  } calib_err_e;
endpackage

// File: rtl/calib_operands.sv
module calib_operands #(
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 64,
  parameter int SCALE_NUM = 10,
  parameter int SCALE_DEN = 2,
  parameter int M_COARSE  = 88,
  parameter int M_FINE    = 264
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic             sel_fine_i,
  output logic [DIV_W-1:0] num_o,
  output logic [DIV_W-1:0] den_o
);
  localparam logic [DIV_W-1:0] K_NUM = DIV_W'(SCALE_NUM);
  localparam logic [DIV_W-1:0] K_DEN = DIV_W'(SCALE_DEN);
  localparam logic [DIV_W-1:0] K_MC  = DIV_W'(M_COARSE);
  localparam logic [DIV_W-1:0] K_MF  = DIV_W'(M_FINE);

  logic [DIV_W-1:0] mult;

  always_comb begin
    mult  = sel_fine_i ? K_MF : K_MC;
    num_o = K_NUM * DIV_W'(period_i) * DIV_W'(ref_i);
    den_o = K_DEN * DIV_W'(dly_i) * mult;
  end
endmodule

// File: rtl/calib_divider.sv
module calib_divider #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q;
  logic [W:0]    rem_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_sh, rem_nx;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q[W-1:0], acc_q[W-1]};
    ge     = rem_sh >= {1'b0, den_q};
    rem_nx = ge ? rem_sh - {1'b0, den_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        acc_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CW'(W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        acc_q <= {acc_q[W-2:0], ge};
        rem_q <= rem_nx;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = acc_q;

  AST_REM_BELOW_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rem_q < {1'b0, den_q})); // R4
endmodule

// File: rtl/calib_param_calc.sv
module calib_param_calc
  import calib_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 64,
  parameter int OUT_W    = 32,
  parameter int M_COARSE = 88,
  parameter int M_FINE   = 264
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REG_W-1:0] period_reg_i,
  input  logic [REG_W-1:0] coarse_reg_i,
  input  logic [REG_W-1:0] fine_reg_i,
  output logic [OUT_W-1:0] coarse_step_o,
  output logic [OUT_W-1:0] fine_step_o,
  output logic             done_o,
  output logic [2:0]       err_o
);
  localparam int DLY_LO = CNT_W;
  localparam int DLY_HI = 2 * CNT_W - 1;

  calib_state_e     state_q;
  calib_err_e       err_q;
  logic [CNT_W-1:0] per_q, c_ref_q, c_dly_q, f_ref_q, f_dly_q;
  logic [OUT_W-1:0] c_tmp_q;
  logic [CNT_W-1:0] op_ref, op_dly;
  logic             sel_fine;
  logic [DIV_W-1:0] div_num, div_den, div_quot;
  logic             div_start, div_busy, div_done;
  logic [OUT_W-1:0] quot_t;

  assign sel_fine  = (state_q == ST_CHK_F) || (state_q == ST_WAIT_F);
  assign op_ref    = sel_fine ? f_ref_q : c_ref_q;
  assign op_dly    = sel_fine ? f_dly_q : c_dly_q;
  assign div_start = ((state_q == ST_CHK_C) && (c_dly_q != '0)) ||
                     ((state_q == ST_CHK_F) && (f_dly_q != '0));
  assign quot_t    = div_quot[OUT_W-1:0];

  calib_operands #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .SCALE_NUM(10), .SCALE_DEN(2),
    .M_COARSE(M_COARSE), .M_FINE(M_FINE)
  ) u_ops (
    .period_i(per_q), .ref_i(op_ref), .dly_i(op_dly),
    .sel_fine_i(sel_fine), .num_o(div_num), .den_o(div_den)
  );

  calib_divider #(.W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .num_i(div_num), .den_i(div_den),
    .busy_o(div_busy), .done_o(div_done), .quot_o(div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      err_q         <= ERR_NONE;
      per_q         <= '0;
      c_ref_q       <= '0;
      c_dly_q       <= '0;
      f_ref_q       <= '0;
      f_dly_q       <= '0;
      c_tmp_q       <= '0;
      coarse_step_o <= '0;
      fine_step_o   <= '0;
      done_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          per_q   <= period_reg_i[CNT_W-1:0];
          c_ref_q <= coarse_reg_i[CNT_W-1:0];
          c_dly_q <= coarse_reg_i[DLY_HI:DLY_LO];
          f_ref_q <= fine_reg_i[CNT_W-1:0];
          f_dly_q <= fine_reg_i[DLY_HI:DLY_LO];
          state_q <= ST_CHK_C;
        end
        ST_CHK_C: if (c_dly_q == '0) begin
          err_q   <= ERR_C_CNT;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_WAIT_C;
        end
        ST_WAIT_C: if (div_done) begin
          if (quot_t == '0) begin
            err_q   <= ERR_C_RES;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            c_tmp_q <= quot_t;
            state_q <= ST_CHK_F;
          end
        end
        ST_CHK_F: if (f_dly_q == '0) begin
          err_q   <= ERR_F_CNT;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_WAIT_F;
        end
        ST_WAIT_F: if (div_done) begin
          if (quot_t == '0) begin
            err_q <= ERR_F_RES;
          end else begin
            err_q         <= ERR_NONE;
            coarse_step_o <= c_tmp_q;
            fine_step_o   <= quot_t;
          end
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign err_o = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_HOLD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o != 3'd0) |-> ($stable(coarse_step_o) && $stable(fine_step_o))); // R10
  AST_OK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 3'd0) |-> (coarse_step_o != '0 && fine_step_o != '0)); // R9
  AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start |-> !div_busy); // R12
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o <= 3'd4)); // R8
endmodule

// File: tb/calib_param_calc_test.sv
module calib_param_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] period_reg = '0, coarse_reg = '0, fine_reg = '0;
  logic [31:0] coarse_step, fine_step;
  logic        done;
  logic [2:0]  err;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_c = '0, exp_f = '0;

  always #2 clk = ~clk;

  calib_param_calc uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .period_reg_i(period_reg), .coarse_reg_i(coarse_reg), .fine_reg_i(fine_reg),
    .coarse_step_o(coarse_step), .fine_step_o(fine_step),
    .done_o(done), .err_o(err)
  );

  function automatic logic [31:0] model(input logic [15:0] p, input logic [15:0] r,
                                        input logic [15:0] d, input int m);
    longint unsigned num, den, q;
    num = 64'(10) * 64'(p) * 64'(r);
    den = 64'(2) * 64'(d) * 64'(m);
    q = num / den;
    return q[31:0];
  endfunction

  task automatic chk(input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] p, input logic [31:0] c,
                     input logic [31:0] f, input bit inject, input string note);
    logic [31:0] cq, fq;
    int e, lat, got;
    string tag;
    cq = '0; fq = '0;
    if (c[31:16] == 16'd0) begin e = 1; lat = 1; end
    else begin
      cq = model(p[15:0], c[15:0], c[31:16], 88);
      if (cq == 0) begin e = 2; lat = 66; end
      else if (f[31:16] == 16'd0) begin e = 3; lat = 67; end
      else begin
        fq = model(p[15:0], f[15:0], f[31:16], 264);
        lat = 132;
        e = (fq == 0) ? 4 : 0;
      end
    end
    case (e)
      1: tag = "R6"; 2: tag = "R7"; 3: tag = "R8"; 4: tag = "R9";
      default: tag = "R11";
    endcase
    tag = {tag, "/", note};
    @(negedge clk);
    start = 1'b1; period_reg = p; coarse_reg = c; fine_reg = f;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (done) begin got = i; break; end
      if (inject && i == 4) begin
        start = 1'b1; period_reg = $urandom; coarse_reg = $urandom; fine_reg = $urandom;
      end
      if (inject && i == 5) start = 1'b0;
    end
    start = 1'b0;
    chk(tag, "latency", got, lat);
    chk(tag, "err code", err, e);
    if (e == 0) begin exp_c = cq; exp_f = fq; end
    chk((e == 0) ? {"R4/", note} : {"R10/", note}, "coarse step", coarse_step, exp_c);
    chk((e == 0) ? {"R5/", note} : {"R10/", note}, "fine step", fine_step, exp_f);
    @(negedge clk);
    chk({"R11/", note}, "done after pulse", done, 0);
    chk({"R10/", note}, "err held", err, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "coarse reset", coarse_step, 0);
    chk("R1", "fine reset", fine_step, 0);
    chk("R1", "done reset", done, 0);
    chk("R1", "err reset", err, 0);

    run(32'hABCD_1F40, {16'd50, 16'd300}, {16'd40, 16'd900}, 1'b0, "R2");
    run(32'h0000_1F40, {16'd50, 16'd300}, {16'd40, 16'd900}, 1'b0, "R2");
    run(32'h0000_1F40, {16'd300, 16'd50}, {16'd900, 16'd40}, 1'b0, "R3");
    run(32'h0000_1F40, {16'd0, 16'd5}, {16'd40, 16'd900}, 1'b0, "R6");
    run(32'h0000_1F40, {16'hFFFF, 16'd0}, {16'd40, 16'd900}, 1'b0, "R7");
    run(32'h0000_1F40, {16'd50, 16'd300}, {16'd0, 16'd100}, 1'b0, "R8");
    run(32'h0000_1F40, {16'd0, 16'd300}, {16'd0, 16'd100}, 1'b0, "R8");
    run(32'h0000_0001, {16'd1, 16'hFFFF}, {16'hFFFF, 16'd1}, 1'b0, "R9");
    run(32'h0000_FFFF, {16'd1, 16'hFFFF}, {16'd1, 16'hFFFF}, 1'b0, "R4");
    run(32'h0000_2000, {16'd7, 16'd4000}, {16'd9, 16'd7000}, 1'b1, "R12");
    run(32'h0000_2000, {16'd0, 16'd4000}, {16'd9, 16'd7000}, 1'b1, "R12");

    for (int k = 0; k < 30; k++) begin
      logic [31:0] p, c, f;
      logic [15:0] cd, fd;
      p = $urandom;
      cd = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom % 2000);
      fd = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom % 2000);
      c = {cd, ($urandom % 8 == 0) ? 16'd0 : 16'($urandom)};
      f = {fd, ($urandom % 8 == 0) ? 16'd0 : 16'($urandom)};
      run(p, c, f, (k % 5) == 0, "R5");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule